// File: doc/BRIEF.md
# TDM Serial Stream Frame Converter

This block sits between a 2048 kbit/s time-division-multiplexed serial backplane stream and byte-wide per-channel storage. It runs on the 4.096 MHz bit clock, so each serial bit cell lasts two clock cycles. An active-low frame pulse sets the frame position. A single frame position counter then produces the bit phase, bit number and channel number.

On the receive side, the serial input is sampled once per bit cell. Each completed byte is written into a 32-entry receive store, which the host reads through a combinational read port. On the transmit side, two 32-entry transmit stores each feed one serial output. The host fills them through a simple write port. Each channel byte is fetched half a slot before it is needed, so the output never stalls. A width select limits the live slots to the first 24 (T1 framing) or allows all 32. A loop select makes the second output replay the serial input one frame later.

Top module: `tdm_frame_conv`

## Requirements
- R1: After reset, and until the first falling edge of `fp_ni` is seen, both serial outputs stay high.
- R2: When `fp_ni` is sampled low on a clock edge after being sampled high on the previous edge, the next cycle is the first cycle of bit 7 (MSB) of channel 0. Each bit cell lasts 2 cycles, each channel 16 cycles and each frame 512 cycles. The position counter then wraps freely.
- R3: In a live slot, `so0_o` carries the byte stored at address c of transmit store 0 (selected by `tx_sel_i` = 0) during channel c, most significant bit first. Each bit is held for both cycles of its cell.
- R4: With `loop_i` low, `so1_o` carries transmit store 1 (`tx_sel_i` = 1) in the same way as R3.
- R5: `si_i` is sampled on the clock edge that ends the second cycle of each bit cell. The first sampled bit becomes the MSB. On the edge that ends channel c's slot, the byte is written to receive address c. It is visible on `rx_rdata_o` for `rx_addr_i` = c from the next cycle.
- R6: With `wide_i` low (24-channel mode), both outputs are high throughout slots 24 to 31.
- R7: With `wide_i` low, slots 24 to 31 write nothing, and those receive addresses keep their earlier bytes.
- R8: With `loop_i` high, the value on `so1_o` in every live bit cell equals the value sampled from `si_i` in the same bit cell one frame (512 cycles) earlier.
- R9: A host write to transmit address c that happens during channel c's slot, or later in the frame, first shows on the output in the following frame.
- R10: A frame pulse falling edge in the middle of a frame restarts the frame at once. In the next cycle channel 0 bit 7 is driven from the store, not from the byte that was being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4.096 MHz bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| fp_ni | input | 1 | Active-low frame pulse |
| wide_i | input | 1 | 1 = 32 live slots, 0 = 24 live slots |
| loop_i | input | 1 | 1 = `so1_o` replays `si_i` one frame later |
| si_i | input | 1 | Serial input stream |
| so0_o | output | 1 | Serial output from transmit store 0 |
| so1_o | output | 1 | Serial output from transmit store 1, or the loop path |
| tx_we_i | input | 1 | Host write strobe for the transmit stores |
| tx_sel_i | input | 1 | Transmit store select for the write |
| tx_addr_i | input | 5 | Transmit channel address |
| tx_wdata_i | input | 8 | Transmit write data |
| rx_addr_i | input | 5 | Receive channel read address |
| rx_rdata_o | output | 8 | Receive byte at `rx_addr_i` (combinational) |

## Verification
The assertions assume that `wide_i` changes only at the start of a bit cell, so an output is never expected to change halfway through a cell. They also assume that the frame pulse stays low for a single cycle.

The stimulus follows these assumptions:
- The frame pulse is driven low for one cycle every 512 cycles, except for one deliberate early pulse that exercises re-alignment.
- `si_i` changes only on the first cycle of a cell.
- Width and loop changes are applied only on the first cycle of a frame.
- Host writes target the channel whose slot is in progress, which makes the next-frame rule of R9 deterministic.

The output checks on `so1_o` are skipped for the one frame in which the loop select toggles. In that frame, channel 0 was fetched under the old setting.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned NUM_SLOTS    = 32;
  localparam int unsigned SLOT_BITS    = 8;
  localparam int unsigned CELL_CLKS    = 2;
  localparam int unsigned NARROW_SLOTS = 24;
  localparam int unsigned NUM_LANES    = 2;
  localparam int unsigned LOOP_LANE    = 1;

  localparam int unsigned CH_W   = $clog2(NUM_SLOTS);
  localparam int unsigned BIT_W  = $clog2(SLOT_BITS);
  localparam int unsigned PH_W   = $clog2(CELL_CLKS);
  localparam int unsigned CNT_W  = CH_W + BIT_W + PH_W;
  localparam int unsigned LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  typedef logic [SLOT_BITS-1:0] slot_byte_t;
  typedef logic [CH_W-1:0]      slot_idx_t;

  typedef struct packed {
    slot_idx_t        chan;
    logic [BIT_W-1:0] bitn;
    logic [PH_W-1:0]  ph;
  } frame_pos_t;
endpackage

// File: rtl/tdm_timebase.sv
module tdm_timebase
  import tdm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fp_ni,
  input  logic       wide_i,
  output frame_pos_t pos_o,
  output logic       resync_o,
  output logic       synced_o,
  output logic       slot_live_o,
  output logic       cell_end_o,
  output logic       slot_end_o,
  output logic       mid_slot_o,
  output slot_idx_t  fetch_o
);
  logic             fp_q, fp_d;
  logic             sync_q, sync_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fall;

  // next state
  always_comb begin
    fall   = fp_q & ~fp_ni;
    fp_d   = fp_ni;
    sync_d = sync_q | fall;
    cnt_d  = fall ? '0 : cnt_q + CNT_W'(1);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_q   <= 1'b1;
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      fp_q   <= fp_d;
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pos_o       = frame_pos_t'(cnt_q);
  assign resync_o    = fall;
  assign synced_o    = sync_q;
  assign slot_live_o = wide_i || (pos_o.chan < CH_W'(NARROW_SLOTS));
  assign cell_end_o  = (pos_o.ph == PH_W'(CELL_CLKS - 1));
  assign slot_end_o  = cell_end_o && (pos_o.bitn == BIT_W'(SLOT_BITS - 1));
  assign mid_slot_o  = cell_end_o && (pos_o.bitn == BIT_W'(SLOT_BITS / 2 - 1));
  assign fetch_o     = fall ? '0 : pos_o.chan + CH_W'(1);
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       si_i,
  input  logic       sample_i,
  input  logic       write_i,
  input  slot_idx_t  waddr_i,
  input  slot_idx_t  raddr_a_i,
  input  slot_idx_t  raddr_b_i,
  output slot_byte_t rdata_a_o,
  output slot_byte_t rdata_b_o
);
  logic [SLOT_BITS-2:0] sh_q, sh_d;
  slot_byte_t           wbyte;
  slot_byte_t           mem_q [NUM_SLOTS];

  // next state: bits enter at the LSB, so the first bit ends as MSB
  always_comb begin
    wbyte = {sh_q, si_i};
    sh_d  = sample_i ? wbyte[SLOT_BITS-2:0] : sh_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  // storage array, written with a clock enable, no reset
  always_ff @(posedge clk_i) begin
    if (write_i) begin
      mem_q[waddr_i] <= wbyte;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
  import tdm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_we_i,
  input  slot_idx_t  host_addr_i,
  input  slot_byte_t host_data_i,
  input  logic       resync_i,
  input  logic       mid_slot_i,
  input  logic       slot_end_i,
  input  logic       cell_end_i,
  input  slot_idx_t  fetch_i,
  input  logic       use_alt_i,
  input  slot_byte_t alt_i,
  output logic       bit_o
);
  slot_byte_t mem_q [NUM_SLOTS];
  slot_byte_t src;
  slot_byte_t hold_q, hold_d;
  slot_byte_t shift_q, shift_d;

  // next state: prefetch mid slot, load at slot end, shift at cell end
  always_comb begin
    src    = use_alt_i ? alt_i : mem_q[fetch_i];
    hold_d = mid_slot_i ? src : hold_q;
    if (resync_i) begin
      shift_d = src;
    end else if (slot_end_i) begin
      shift_d = hold_q;
    end else if (cell_end_i) begin
      shift_d = shift_q << 1;
    end else begin
      shift_d = shift_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '1;
      shift_q <= '1;
    end else begin
      hold_q  <= hold_d;
      shift_q <= shift_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (host_we_i) begin
      mem_q[host_addr_i] <= host_data_i;
    end
  end

  assign bit_o = shift_q[SLOT_BITS-1];
endmodule

// File: rtl/tdm_frame_conv.sv
module tdm_frame_conv
  import tdm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fp_ni,
  input  logic                 wide_i,
  input  logic                 loop_i,
  input  logic                 si_i,
  output logic                 so0_o,
  output logic                 so1_o,
  input  logic                 tx_we_i,
  input  logic [LANE_W-1:0]    tx_sel_i,
  input  logic [CH_W-1:0]      tx_addr_i,
  input  logic [SLOT_BITS-1:0] tx_wdata_i,
  input  logic [CH_W-1:0]      rx_addr_i,
  output logic [SLOT_BITS-1:0] rx_rdata_o
);
  logic           rst_meta_q, rst_n_w;
  frame_pos_t     pos_w;
  logic           resync_w, sync_w, live_w, cell_end_w, slot_end_w, mid_slot_w;
  slot_idx_t      fetch_w;
  logic           rx_we_w;
  slot_byte_t     rx_alt_w;
  logic [NUM_LANES-1:0] lane_bit;
  logic           drive_w;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_w    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_w    <= rst_meta_q;
    end
  end

  tdm_timebase u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_w),
    .fp_ni      (fp_ni),
    .wide_i     (wide_i),
    .pos_o      (pos_w),
    .resync_o   (resync_w),
    .synced_o   (sync_w),
    .slot_live_o(live_w),
    .cell_end_o (cell_end_w),
    .slot_end_o (slot_end_w),
    .mid_slot_o (mid_slot_w),
    .fetch_o    (fetch_w)
  );

  assign rx_we_w = sync_w && live_w && slot_end_w;

  tdm_rx u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_w),
    .si_i     (si_i),
    .sample_i (cell_end_w),
    .write_i  (rx_we_w),
    .waddr_i  (pos_w.chan),
    .raddr_a_i(rx_addr_i),
    .raddr_b_i(fetch_w),
    .rdata_a_o(rx_rdata_o),
    .rdata_b_o(rx_alt_w)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic lane_we;
    logic alt_en;
    assign lane_we = tx_we_i && (tx_sel_i == LANE_W'(g));
    if (g == LOOP_LANE) begin : g_loop
      assign alt_en = loop_i;
    end else begin : g_plain
      assign alt_en = 1'b0;
    end
    tdm_tx_lane u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_n_w),
      .host_we_i  (lane_we),
      .host_addr_i(tx_addr_i),
      .host_data_i(tx_wdata_i),
      .resync_i   (resync_w),
      .mid_slot_i (mid_slot_w),
      .slot_end_i (slot_end_w),
      .cell_end_i (cell_end_w),
      .fetch_i    (fetch_w),
      .use_alt_i  (alt_en),
      .alt_i      (rx_alt_w),
      .bit_o      (lane_bit[g])
    );
  end

  assign drive_w = sync_w && live_w;
  assign so0_o   = drive_w ? lane_bit[0] : 1'b1;
  assign so1_o   = drive_w ? lane_bit[1] : 1'b1;
endmodule

// File: rtl/tdm_frame_conv_chk.sv
module tdm_frame_conv_chk
  import tdm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fp_ni,
  input logic             wide_i,
  input logic             so0_i,
  input logic             so1_i,
  input logic             synced_i,
  input logic             rx_we_i,
  input logic [CNT_W-1:0] pos_i
);
  logic             fp_prev_q;
  logic [CH_W-1:0]  ch_w;
  logic [BIT_W-1:0] bit_w;
  logic [PH_W-1:0]  ph_w;

  assign ch_w  = pos_i[CNT_W-1 -: CH_W];
  assign bit_w = pos_i[PH_W +: BIT_W];
  assign ph_w  = pos_i[PH_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fp_prev_q <= 1'b1;
    else         fp_prev_q <= fp_ni;
  end

  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_i |-> (so0_i && so1_i && !rx_we_i));

  // R2
  frame_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_prev_q && !fp_ni) |=> (pos_i == '0));

  // R3
  cell_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced_i && ph_w != '0) |-> ($stable(so0_i) && $stable(so1_i)));

  // R5
  write_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_we_i |-> (bit_w == BIT_W'(SLOT_BITS - 1) && ph_w == PH_W'(CELL_CLKS - 1)));

  // R6
  narrow_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (synced_i && !wide_i && ch_w >= CH_W'(NARROW_SLOTS)) |-> (so0_i && so1_i));

  // R7
  narrow_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_we_i |-> (wide_i || ch_w < CH_W'(NARROW_SLOTS)));
endmodule

bind tdm_frame_conv tdm_frame_conv_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_n_w),
  .fp_ni   (fp_ni),
  .wide_i  (wide_i),
  .so0_i   (so0_o),
  .so1_i   (so1_o),
  .synced_i(sync_w),
  .rx_we_i (rx_we_w),
  .pos_i   (pos_w)
);

// File: tb/tdm_frame_conv_test.sv
module tdm_frame_conv_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fp_ni = 1'b1;
  logic       wide_i = 1'b1;
  logic       loop_i = 1'b0;
  logic       si_i = 1'b1;
  logic       so0_o, so1_o;
  logic       tx_we_i = 1'b0;
  logic [0:0] tx_sel_i = '0;
  logic [4:0] tx_addr_i = '0;
  logic [7:0] tx_wdata_i = '0;
  logic [4:0] rx_addr_i = '0;
  logic [7:0] rx_rdata_o;

  always #2 clk = ~clk;

  tdm_frame_conv uut (
    .clk_i(clk), .rst_ni(rst_ni), .fp_ni(fp_ni), .wide_i(wide_i), .loop_i(loop_i),
    .si_i(si_i), .so0_o(so0_o), .so1_o(so1_o), .tx_we_i(tx_we_i), .tx_sel_i(tx_sel_i),
    .tx_addr_i(tx_addr_i), .tx_wdata_i(tx_wdata_i), .rx_addr_i(rx_addr_i),
    .rx_rdata_o(rx_rdata_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] txm [2][32];
  logic [7:0] txn [2][32];
  bit         wr_now [2][32];
  bit         wr_prev [2][32];
  logic [7:0] rxm [32];
  bit         rxk [32];
  bit         si_cur [512];
  bit         si_prev [512];
  bit         skip1 = 0;
  bit         post_rs = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit live(input int ch);
    return wide_i || (ch < 24);
  endfunction

  function automatic logic exp_tx(input int ln, input int ch, input int b);
    return live(ch) ? txm[ln][ch][7-b] : 1'b1;
  endfunction

  function automatic logic exp_loop(input int p);
    return live(p / 16) ? si_prev[p | 1] : 1'b1;
  endfunction

  // one frame; starts and ends at a falling edge
  task automatic run_frame(input int rs_at);
    for (int p = 0; p < 512; p++) begin
      int    ch;
      int    b;
      string t0;
      string t1;
      logic [7:0] rb;
      ch = p / 16;
      b  = (p / 2) % 8;
      if (p % 2 == 0) si_i = 1'($urandom_range(0, 1));
      si_cur[p] = si_i;
      fp_ni   = (p == 511 || p == rs_at) ? 1'b0 : 1'b1;
      tx_we_i = 1'b0;
      if (p % 16 == 4 && $urandom_range(0, 1) == 1) begin
        int         ln;
        logic [7:0] d;
        ln = $urandom_range(0, 1);
        d  = 8'($urandom);
        tx_we_i    = 1'b1;
        tx_sel_i   = 1'(ln);
        tx_addr_i  = 5'(ch);
        tx_wdata_i = d;
        txn[ln][ch]    = d;
        wr_now[ln][ch] = 1;
      end
      rx_addr_i = 5'(ch);
      #1;
      t0 = !live(ch) ? "R6" : (post_rs && p < 16) ? "R10" : (p < 2) ? "R2" :
           wr_prev[0][ch] ? "R9" : "R3";
      chk(t0, so0_o, exp_tx(0, ch, b));
      if (!skip1) begin
        t1 = !live(ch) ? "R6" : loop_i ? "R8" : wr_prev[1][ch] ? "R9" : "R4";
        chk(t1, so1_o, loop_i ? exp_loop(p) : exp_tx(1, ch, b));
      end
      if (p % 16 == 0 && rxk[ch]) chk(live(ch) ? "R5" : "R7", rx_rdata_o, rxm[ch]);
      @(posedge clk);
      if (p % 16 == 15 && live(ch)) begin
        rb = '0;
        for (int k = 0; k < 8; k++) rb = {rb[6:0], si_cur[ch*16 + 2*k + 1]};
        rxm[ch] = rb;
        rxk[ch] = 1;
      end
      @(negedge clk);
      if (p == rs_at) break;
    end
    for (int l = 0; l < 2; l++)
      for (int c = 0; c < 32; c++) begin
        txm[l][c]     = txn[l][c];
        wr_prev[l][c] = wr_now[l][c];
        wr_now[l][c]  = 0;
      end
    for (int i = 0; i < 512; i++) si_prev[i] = si_cur[i];
    post_rs = (rs_at >= 0);
  endtask

  task automatic frame(input bit w, input bit lp, input bit sk, input int rs_at);
    wide_i = w;
    loop_i = lp;
    skip1  = sk;
    run_frame(rs_at);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1457));
    for (int i = 0; i < 32; i++) rxk[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1: host loads both stores while unframed; outputs stay high
    for (int l = 0; l < 2; l++)
      for (int c = 0; c < 32; c++) begin
        logic [7:0] d;
        d = (c == 0 || c == 31) ? ((l == 0) ? 8'h81 : 8'h7E) : 8'($urandom);
        tx_we_i = 1'b1; tx_sel_i = 1'(l); tx_addr_i = 5'(c); tx_wdata_i = d;
        txm[l][c] = d; txn[l][c] = d; wr_now[l][c] = 0; wr_prev[l][c] = 0;
        si_i = 1'($urandom_range(0, 1));
        #1;
        if (c % 8 == 0) begin
          chk("R1", so0_o, 1);
          chk("R1", so1_o, 1);
        end
        @(negedge clk);
      end
    tx_we_i = 1'b0;
    fp_ni = 1'b0;
    #1;
    chk("R1", so0_o, 1);
    chk("R1", so1_o, 1);
    @(negedge clk);
    frame(1, 0, 0, -1);
    frame(1, 0, 0, -1);
    frame(0, 0, 0, -1);   // R6, R7
    frame(0, 0, 0, -1);
    frame(1, 1, 1, -1);   // loop turns on
    frame(1, 1, 0, -1);   // R8
    frame(1, 1, 0, -1);
    frame(0, 1, 0, -1);
    frame(1, 0, 1, -1);   // loop turns off
    frame(1, 0, 0, 200);  // R10: early pulse
    frame(1, 0, 0, -1);
    frame(1, 0, 0, -1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule